// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This engine walks a ring of transmit descriptors held in system memory and turns the buffers they point at into a stream of frame bytes. Every descriptor takes two 32-bit words. The first word holds a 16-bit flag field and a 16-bit byte count. The second word holds the byte address of the data buffer. The engine reads the data bytes through a 32-bit request/ready memory port and emits them one per beat with valid/ready handshaking. A frame may span several descriptors, and the frame-end marker sits on the final byte. After each descriptor has been used, the engine writes it back with its ready flag cleared, so software can reuse the slot.

Software programs three locations through a small write port. Address 0 is control, and its bit 1 enables the engine. Address 1 is the ring start, which takes any byte address. A write to address 2 activates a walk. The walk runs until it fetches a descriptor that software has not marked ready. The engine then parks on that descriptor, so the next activation resumes there. Three single-cycle event pulses go to an interrupt block: buffer done, frame done, and an oversize-frame error.

Top module: `tx_desc_ring`

## Requirements
- R1: After reset, busy_o, tx_valid_o, mem_req_o and all three event outputs are 0.
- R2: A write to address 2 starts a walk only if bit 1 of the last value written to address 0 is 1. In any other case the write has no effect.
- R3: Descriptor word 0 holds the flags in [31:16] and the byte count in [15:0]. Word 1, at the descriptor address plus 4, holds the buffer byte address. Flag bit 15 is ready. If a fetched descriptor has ready = 0, the walk ends and the engine keeps that descriptor's address as its current pointer.
- R4: Buffer bytes go out in ascending address order, from any starting byte alignment. Within each memory word the bytes are big-endian, so the lowest address is bits [31:24]. Frames are concatenated across descriptors up to one whose flag bit 11 (last) is set. tx_last_o is 1 on exactly the final byte of the frame.
- R5: Each descriptor the engine processes is written back to word 0 with bit 15 cleared. Its other flag bits and its byte count stay unchanged. evt_txb_o pulses once per descriptor.
- R6: evt_txf_o pulses once for each descriptor that has flag bit 11 set.
- R7: After a descriptor with flag bit 13 (wrap) set, the next descriptor is fetched at the ring start. Otherwise it is fetched at the current address plus 8.
- R8: A frame never exceeds MAX_FRAME bytes (2032 by default). When a descriptor would go past the limit, only the bytes that still fit are sent and evt_babble_o pulses. tx_last_o still marks the last byte sent, even when the final descriptor adds no bytes.
- R9: A write to address 1 sets the ring start to the written value with bits [1:0] forced to 0. If the engine is idle, the write also reloads the current descriptor pointer.
- R10: busy_o, the activation readback, is 0 while idle and 1 while a walk is in progress.
- R11: While tx_valid_o is 1 and tx_ready_i is 0, tx_valid_o, tx_data_o and tx_last_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | 0 control, 1 ring start, 2 activate |
| cfg_wdata_i | input | 32 | Configuration write data |
| busy_o | output | 1 | Activation readback, 1 while walking |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Memory completes the request this cycle |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_data_o | output | 8 | Frame byte |
| tx_last_o | output | 1 | Final byte of frame |
| tx_ready_i | input | 1 | Sink accepts the byte |
| evt_txb_o | output | 1 | Buffer-done pulse |
| evt_txf_o | output | 1 | Frame-done pulse |
| evt_babble_o | output | 1 | Oversize-frame pulse |

## Verification
The bench builds the engine with its default MAX_FRAME of 2032 against an 8 KB word memory. That memory is large enough to hold real full-size buffers. With it the bench can reach both truncation cases: a frame that lands exactly on the limit and is then closed by an empty last descriptor, and a frame whose final descriptor is cut partway through. Memory ready and sink ready are throttled in fixed, unequal rhythms. This makes word refetches, stalled beats and the held-back final byte line up differently across the frames.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int FLAG_READY = 15;
  localparam int FLAG_WRAP  = 13;
  localparam int FLAG_LAST  = 11;
  localparam int CTRL_EN    = 1;
  localparam logic [1:0] CFG_CTRL = 2'd0;
  localparam logic [1:0] CFG_RING = 2'd1;
  localparam logic [1:0] CFG_KICK = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DESC0, ST_DESC1, ST_RDW, ST_EMIT, ST_FLUSH, ST_WB
  } st_e;
endpackage

// File: rtl/tdr_regs.sv
module tdr_regs
  import tdr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [AW-1:0] cfg_wdata_i,
  output logic          en_o,
  output logic [AW-1:0] ring_base_o,
  output logic          base_load_o,
  output logic [AW-1:0] base_val_o,
  output logic          kick_o
);
  logic unused_bit;
  assign unused_bit = cfg_wdata_i[0];

  assign base_val_o  = {cfg_wdata_i[AW-1:2], 2'b00};
  assign base_load_o = cfg_we_i && (cfg_addr_i == CFG_RING);
  assign kick_o      = cfg_we_i && (cfg_addr_i == CFG_KICK) && en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o        <= 1'b0;
      ring_base_o <= '0;
    end else begin
      if (cfg_we_i && cfg_addr_i == CFG_CTRL) en_o <= cfg_wdata_i[CTRL_EN];
      if (base_load_o) ring_base_o <= base_val_o;
    end
  end
endmodule

// File: rtl/tdr_len_cap.sv
module tdr_len_cap #(
  parameter int MAX_FRAME = 2032,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [15:0]      len_i,
  output logic [15:0]      take_o,
  output logic             trunc_o
);
  logic [16:0] room;
  logic unused_room;
  assign room        = 17'(MAX_FRAME) - 17'(cnt_i);
  assign unused_room = room[16];
  assign trunc_o     = {1'b0, len_i} > room;
  assign take_o      = trunc_o ? room[15:0] : len_i;
endmodule

// File: rtl/tdr_byte_out.sv
module tdr_byte_out (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic [7:0] push_data_i,
  output logic       push_ack_o,
  input  logic       flush_i,
  output logic       flush_ack_o,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       tx_last_o,
  input  logic       tx_ready_i
);
  // one byte is held back until it is known whether it ends the frame
  logic       h_vld;
  logic [7:0] h_data;
  logic       out_free;

  assign out_free    = !tx_valid_o || tx_ready_i;
  assign push_ack_o  = push_i  && (!h_vld || out_free);
  assign flush_ack_o = flush_i && (!h_vld || out_free);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_vld      <= 1'b0;
      h_data     <= '0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      tx_last_o  <= 1'b0;
    end else begin
      if (tx_valid_o && tx_ready_i) tx_valid_o <= 1'b0;
      if (push_ack_o) begin
        if (h_vld) begin
          tx_valid_o <= 1'b1;
          tx_data_o  <= h_data;
          tx_last_o  <= 1'b0;
        end
        h_vld  <= 1'b1;
        h_data <= push_data_i;
      end else if (flush_ack_o && h_vld) begin
        tx_valid_o <= 1'b1;
        tx_data_o  <= h_data;
        tx_last_o  <= 1'b1;
        h_vld      <= 1'b0;
      end
    end
  end

  a_r11_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));
endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring
  import tdr_pkg::*;
#(
  parameter int MAX_FRAME = 2032
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [1:0]  cfg_addr_i,
  input  logic [31:0] cfg_wdata_i,
  output logic        busy_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_ready_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i,
  output logic        evt_txb_o,
  output logic        evt_txf_o,
  output logic        evt_babble_o
);
  localparam int CNT_W = $clog2(MAX_FRAME + 1);

  st_e              st_q;
  logic [31:0]      cur_q, dptr_q, word_q;
  logic [15:0]      flags_q, len_q, rem_q;
  logic [CNT_W-1:0] fcnt_q;
  logic             en, base_load, kick;
  logic [31:0]      ring_base, base_val;
  logic [15:0]      take;
  logic             trunc, hs;
  logic             push_ack, flush_ack;
  logic [7:0]       cur_byte;

  tdr_regs #(.AW(32)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .en_o(en), .ring_base_o(ring_base), .base_load_o(base_load),
    .base_val_o(base_val), .kick_o(kick)
  );

  tdr_len_cap #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_cap (
    .cnt_i(fcnt_q), .len_i(len_q), .take_o(take), .trunc_o(trunc)
  );

  always_comb begin
    case (dptr_q[1:0])
      2'd0:    cur_byte = word_q[31:24];
      2'd1:    cur_byte = word_q[23:16];
      2'd2:    cur_byte = word_q[15:8];
      default: cur_byte = word_q[7:0];
    endcase
  end

  tdr_byte_out u_out (
    .clk_i, .rst_ni,
    .push_i(st_q == ST_EMIT), .push_data_i(cur_byte), .push_ack_o(push_ack),
    .flush_i(st_q == ST_FLUSH), .flush_ack_o(flush_ack),
    .tx_valid_o, .tx_data_o, .tx_last_o, .tx_ready_i
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_q;
    mem_wdata_o = {1'b0, flags_q[14:0], len_q};
    case (st_q)
      ST_DESC0: mem_req_o = 1'b1;
      ST_DESC1: begin mem_req_o = 1'b1; mem_addr_o = cur_q + 32'd4; end
      ST_RDW:   begin mem_req_o = 1'b1; mem_addr_o = {dptr_q[31:2], 2'b00}; end
      ST_WB:    begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      default:  ;
    endcase
  end

  assign hs     = mem_req_o && mem_ready_i;
  assign busy_o = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      cur_q <= '0; dptr_q <= '0; word_q <= '0;
      flags_q <= '0; len_q <= '0; rem_q <= '0; fcnt_q <= '0;
      evt_txb_o <= 1'b0; evt_txf_o <= 1'b0; evt_babble_o <= 1'b0;
    end else begin
      evt_txb_o    <= 1'b0;
      evt_txf_o    <= 1'b0;
      evt_babble_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (kick) st_q <= ST_DESC0;
        ST_DESC0: if (hs) begin
          flags_q <= mem_rdata_i[31:16];
          len_q   <= mem_rdata_i[15:0];
          st_q    <= mem_rdata_i[16+FLAG_READY] ? ST_DESC1 : ST_IDLE;
        end
        ST_DESC1: if (hs) begin
          dptr_q       <= mem_rdata_i;
          rem_q        <= take;
          fcnt_q       <= fcnt_q + take[CNT_W-1:0];
          evt_babble_o <= trunc;
          if (take != 16'd0)           st_q <= ST_RDW;
          else if (flags_q[FLAG_LAST]) st_q <= ST_FLUSH;
          else                         st_q <= ST_WB;
        end
        ST_RDW: if (hs) begin
          word_q <= mem_rdata_i;
          st_q   <= ST_EMIT;
        end
        ST_EMIT: if (push_ack) begin
          dptr_q <= dptr_q + 32'd1;
          rem_q  <= rem_q - 16'd1;
          if (rem_q == 16'd1)           st_q <= flags_q[FLAG_LAST] ? ST_FLUSH : ST_WB;
          else if (dptr_q[1:0] == 2'd3) st_q <= ST_RDW;
        end
        ST_FLUSH: if (flush_ack) begin
          fcnt_q    <= '0;
          evt_txf_o <= 1'b1;
          st_q      <= ST_WB;
        end
        ST_WB: if (hs) begin
          evt_txb_o <= 1'b1;
          cur_q     <= flags_q[FLAG_WRAP] ? ring_base : cur_q + 32'd8;
          st_q      <= ST_DESC0;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (base_load && st_q == ST_IDLE) cur_q <= base_val;
    end
  end

  a_r8_frame_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fcnt_q) <= MAX_FRAME);
  a_r2_start_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cfg_we_i && cfg_addr_i == CFG_KICK && en));
  a_r3_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  a_r5_txb_after_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_txb_o |-> $past(mem_req_o && mem_we_o && mem_ready_i));
endmodule

// File: tb/tb_tx_desc_ring.sv
module tb_tx_desc_ring;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        busy, mem_req, mem_we, mem_ready, tx_valid, tx_last, tx_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  tx_data;
  logic        evt_txb, evt_txf, evt_bab;

  tx_desc_ring dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .busy_o(busy), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_ready_i(tx_ready), .evt_txb_o(evt_txb),
    .evt_txf_o(evt_txf), .evt_babble_o(evt_bab)
  );

  logic [31:0] mem [0:2047];
  int unsigned cyc = 0;
  assign mem_rdata = mem[mem_addr[12:2]];
  always @(posedge clk) begin
    cyc       <= cyc + 1;
    mem_ready <= (cyc % 3) != 0;
    tx_ready  <= (cyc % 5) != 2;
    if (mem_req && mem_we && mem_ready) mem[mem_addr[12:2]] <= mem_wdata;
  end

  int n_chk = 0, n_fail = 0;
  int n_txb = 0, n_txf = 0, n_bab = 0;
  logic [8:0] exp_q[$];
  bit stall_prev = 0;
  logic [8:0] stall_val;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_txb) n_txb++;
      if (evt_txf) n_txf++;
      if (evt_bab) n_bab++;
      if (stall_prev)
        chk(tx_valid && {tx_last, tx_data} == stall_val, "R11 stalled beat held",
            {tx_valid, tx_last, tx_data}, {1'b1, stall_val});
      stall_prev = tx_valid && !tx_ready;
      stall_val  = {tx_last, tx_data};
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected byte", {tx_last, tx_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({tx_last, tx_data} == e, "R4/R8 byte/last", {tx_last, tx_data}, e);
        end
      end
    end
  end

  task automatic cfg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_byte(input int a, input logic [7:0] b);
    mem[a >> 2][8*(3 - (a % 4)) +: 8] = b;
  endtask

  task automatic put_desc(input int a, input logic [15:0] fl, input logic [15:0] len, input int bufa);
    mem[a >> 2]       = {fl, len};
    mem[(a >> 2) + 1] = bufa;
  endtask

  task automatic fill_buf(input int a, input int len, input int take, input int seed);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'(seed + i * 7);
      set_byte(a + i, b);
      if (i < take) exp_q.push_back({1'b0, b});
    end
  endtask

  task automatic mark_last();
    logic [8:0] t;
    t = exp_q.pop_back();
    t[8] = 1'b1;
    exp_q.push_back(t);
  endtask

  task automatic wait_done();
    int t = 0;
    @(negedge clk);
    while ((busy || exp_q.size() != 0 || tx_valid) && t < 30000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 30000, "R3 walk ends", t, 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !tx_valid && !mem_req && !evt_txb && !evt_txf && !evt_bab,
        "R1 reset outputs", {busy, tx_valid, mem_req, evt_txb, evt_txf, evt_bab}, 0);
    rst_n = 1'b1;
    cfg(2'd0, 32'h2);

    // single-buffer frame, unaligned start
    cfg(2'd1, 32'h40);
    put_desc(32'h40, 16'h8800, 16'd5, 32'h203);
    fill_buf(32'h203, 5, 5, 8'h11); mark_last();
    cfg(2'd2, 0);
    chk(busy, "R10 busy while walking", busy, 1);
    wait_done();
    chk(!busy, "R10 idle readback zero", busy, 0);
    chk(mem[32'h40 >> 2] == {16'h0800, 16'd5}, "R5 write-back clears ready", mem[32'h40 >> 2], {16'h0800, 16'd5});
    chk(n_txb == 1 && n_txf == 1 && n_bab == 0, "R5 R6 event counts single", {n_txb, n_txf, n_bab}, {32'd1, 32'd1, 32'd0});

    // three-buffer frame resuming at parked pointer 0x48
    put_desc(32'h48, 16'h8000, 16'd3, 32'h301);
    put_desc(32'h50, 16'h8000, 16'd4, 32'h322);
    put_desc(32'h58, 16'h8800, 16'd2, 32'h343);
    fill_buf(32'h301, 3, 3, 8'h40);
    fill_buf(32'h322, 4, 4, 8'h60);
    fill_buf(32'h343, 2, 2, 8'h80); mark_last();
    cfg(2'd2, 0);
    wait_done();
    chk(n_txb == 4 && n_txf == 2, "R6 R7 multi-buffer events", {n_txb, n_txf}, {32'd4, 32'd2});
    chk(mem[32'h50 >> 2] == {16'h0000, 16'd4}, "R5 middle write-back", mem[32'h50 >> 2], {16'h0000, 16'd4});

    // wrap, low-bit masking of ring start
    cfg(2'd1, 32'h103);
    put_desc(32'h100, 16'h8000, 16'd6, 32'h400);
    put_desc(32'h108, 16'hA800, 16'd3, 32'h420);
    fill_buf(32'h400, 6, 6, 8'h21);
    fill_buf(32'h420, 3, 3, 8'h31); mark_last();
    cfg(2'd2, 0);
    wait_done();
    chk(mem[32'h108 >> 2] == {16'h2800, 16'd3}, "R9 masked start, R5 wrap write-back", mem[32'h108 >> 2], {16'h2800, 16'd3});
    put_desc(32'h100, 16'h8800, 16'd2, 32'h440);
    fill_buf(32'h440, 2, 2, 8'h55); mark_last();
    cfg(2'd2, 0);
    wait_done();
    chk(n_txf == 4 && mem[32'h100 >> 2] == {16'h0800, 16'd2}, "R7 R3 wrap returns to start and parks",
        mem[32'h100 >> 2], {16'h0800, 16'd2});

    // activation ignored with enable clear
    put_desc(32'h108, 16'h8800, 16'd1, 32'h460);
    cfg(2'd0, 32'h0);
    cfg(2'd2, 0);
    repeat (6) @(negedge clk);
    chk(!busy && mem[32'h108 >> 2][31], "R2 no walk when disabled", {busy, mem[32'h108 >> 2][31]}, 1);
    fill_buf(32'h460, 1, 1, 8'h99); mark_last();
    cfg(2'd0, 32'h2);
    cfg(2'd2, 0);
    wait_done();
    chk(mem[32'h108 >> 2] == {16'h0800, 16'd1}, "R2 walk after enable", mem[32'h108 >> 2], {16'h0800, 16'd1});

    // exact cap reached, empty closing descriptor
    cfg(2'd1, 32'h800);
    put_desc(32'h800, 16'h8000, 16'd2000, 32'h1000);
    put_desc(32'h808, 16'h8000, 16'd32, 32'h1800);
    put_desc(32'h810, 16'h8800, 16'd10, 32'h1900);
    fill_buf(32'h1000, 2000, 2000, 8'h03);
    fill_buf(32'h1800, 32, 32, 8'h70);
    fill_buf(32'h1900, 10, 0, 8'h7F); mark_last();
    cfg(2'd2, 0);
    wait_done();
    chk(n_bab == 1 && n_txf == 6, "R8 cap with empty last", {n_bab, n_txf}, {32'd1, 32'd6});

    // partial cut of final descriptor
    put_desc(32'h818, 16'h8000, 16'd2030, 32'h1000);
    put_desc(32'h820, 16'h8800, 16'd5, 32'h1900);
    fill_buf(32'h1000, 2030, 2030, 8'h0B);
    fill_buf(32'h1900, 5, 2, 8'hC1); mark_last();
    cfg(2'd2, 0);
    wait_done();
    chk(n_bab == 2 && mem[32'h820 >> 2] == {16'h0800, 16'd5}, "R8 partial cut keeps count in write-back",
        mem[32'h820 >> 2], {16'h0800, 16'd5});

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule